// File: doc/BRIEF.md
# Serial-Interface Nonvolatile Memory Slave Model

This block behaves like a three-wire serial EEPROM slave. A host drives chip select, a serial clock and a serial data line. The block drives a serial data output and an output enable that controls a tri-state pad. Every signal from the host is synchronized into a fast system clock, and the block acts on the edges it detects there. Each instruction is a start bit, a two-bit opcode and an address, followed by a data field for the operations that store data. The block reads, writes and erases single words, and it can also erase or fill the whole array. A software enable latch and a program-enable pin both guard every operation that changes memory.

The organization pin picks 16-bit or 8-bit words. Both organizations share one storage array built from two byte lanes. Any store or erase begins when chip select falls, and then runs for a fixed number of system cycles. During that time the block reports busy on the data output whenever chip select is high. Reads can continue across word boundaries and wrap from the last address back to address zero.

Top module: `mw_eeprom`

## Requirements
- R1: An instruction starts at the first 1 sampled on a rising serial clock while selected; 0 bits before it are ignored. The start bit is followed by a 2-bit opcode (10 read, 01 write, 11 erase, 00 special group) and then the address, MSB first: ADDR_BITS bits when org16_i=1, ADDR_BITS+1 bits when org16_i=0.
- R2: In the special group, the two most significant address bits select the operation: 11 sets the write enable, 00 clears it, 10 erases the whole array, 01 fills the whole array with the data word that follows. The other address bits are ignored.
- R3: After the last read address bit, the data output is enabled and first shows a single 0. Each later rising serial clock then presents the next bit of the addressed word, MSB first.
- R4: If the host keeps clocking, the following words come out back to back with no extra 0 bit. The address after the last location (MEM_WORDS words in 16-bit mode, 2*MEM_WORDS bytes in 8-bit mode) is 0.
- R5: A write stores its data when chip select falls, with no erase needed beforehand. Data is 16 bits in 16-bit mode and 8 bits in 8-bit mode, MSB first.
- R6: An erase sets the addressed location to all ones. An erase-all sets every location to all ones.
- R7: A fill stores its data word in every location. In 8-bit mode, every byte receives the data byte.
- R8: After reset, writes are disabled. Write, erase, erase-all and fill have no effect while writes are disabled or pe_i is 0. Setting or clearing the enable works whatever the value of pe_i.
- R9: A started operation keeps the block busy for PROG_CYCLES system cycles (at least MEM_WORDS+1). While it is busy and selected, the output is enabled and shows 0. Once it is ready, the output shows 1. Instructions sent while busy are ignored.
- R10: After the ready indication, a 1 clocked in returns the output enable to 0 at the next falling serial clock.
- R11: In 8-bit mode, byte address a maps to 16-bit word a>>1. An even address is the high byte of that word and an odd address is the low byte.
- R12: Dropping chip select before an instruction is complete aborts it and leaves memory unchanged.
- R13: Address bits above log2 of the depth are ignored.
- R14: The output enable is 0 after reset and whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| pe_i | input | 1 | Program enable; must be 1 for any change to memory |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for the data-out pad |

## Verification
The bench builds the block with MEM_WORDS=16 so that a sequential read can run past the last word and wrap within a few thousand cycles. The same depth lets an address above the depth alias back onto a real location. PROG_CYCLES=400 keeps a busy period long enough to clock a complete erase instruction into the block while it is still busy. The busy length can then be measured against the parameter. ADDR_BITS stays at 10, so the header lengths and the position of the special-group selector match full-size use in both organizations.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_ERASE   = 2'b11;

  localparam logic [1:0] SEL_WDIS = 2'b00;
  localparam logic [1:0] SEL_FILL = 2'b01;
  localparam logic [1:0] SEL_WIPE = 2'b10;
  localparam logic [1:0] SEL_WEN  = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_READ, S_ARMED, S_DONE
  } dec_st_t;

  typedef enum logic [1:0] {
    P_WRITE, P_ERASE, P_WIPE, P_FILL
  } pgm_op_t;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      d_q  <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  assign sync_o = s2_q;
  assign rise_o = s2_q & ~d_q;
  assign fall_o = ~s2_q & d_q;
endmodule

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          we_hi,
  input  logic          we_lo,
  input  logic [IW-1:0] widx,
  input  logic [15:0]   wdata,
  input  logic [IW-1:0] ridx,
  output logic [15:0]   rdata
);
  localparam int DEPTH = 1 << IW;

  logic [7:0] hi_q [DEPTH];
  logic [7:0] lo_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_hi) hi_q[widx] <= wdata[15:8];
    if (we_lo) lo_q[widx] <= wdata[7:0];
    rdata <= {hi_q[ridx], lo_q[ridx]};
  end
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_BITS = 10,
  parameter int IW        = 6,
  parameter int MEM_WORDS = 64,
  parameter int PROG_T    = 500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          cs_fall,
  input  logic          sk_rise,
  input  logic          sk_fall,
  input  logic          di_s,
  input  logic          org16,
  input  logic          pe,
  input  logic [15:0]   rdata,
  output logic [IW-1:0] ridx,
  output logic          we_hi,
  output logic          we_lo,
  output logic [IW-1:0] widx,
  output logic [15:0]   wdata,
  output logic          busy_o,
  output logic          wen_o,
  output logic          stat_o,
  output logic          rd_oe_o,
  output logic          rd_do_o
);
  localparam int HW = ADDR_BITS + 3;
  localparam int CW = $clog2(ADDR_BITS + 20);
  localparam int PW = $clog2(PROG_T + 1);

  dec_st_t        st;
  logic [CW-1:0]  bcnt;
  logic [HW-1:0]  hdr_q, hdr_n;
  logic [15:0]    dat_q, sh_q, ld_word;
  logic [IW:0]    raddr, raddr_inc, arm_addr, pgm_addr, a_dec;
  logic [4:0]     wcnt;
  logic [1:0]     op_dec, sel_dec;
  logic [CW-1:0]  hlast, dlast;
  pgm_op_t        arm_op, pgm_op;
  logic [15:0]    pgm_data;
  logic           pgm_org, busy, wen, stat_pend, stat_clr, rd_oe, rd_do;
  logic [PW-1:0]  pcnt;
  logic           all_op;

  always_comb begin
    hdr_n   = {hdr_q[HW-2:0], di_s};
    hlast   = org16 ? CW'(ADDR_BITS + 1) : CW'(ADDR_BITS + 2);
    dlast   = org16 ? CW'(15) : CW'(7);
    op_dec  = org16 ? hdr_n[ADDR_BITS+1:ADDR_BITS] : hdr_n[ADDR_BITS+2:ADDR_BITS+1];
    sel_dec = org16 ? hdr_n[ADDR_BITS-1:ADDR_BITS-2] : hdr_n[ADDR_BITS:ADDR_BITS-1];
    a_dec   = org16 ? {1'b0, hdr_n[IW-1:0]} : hdr_n[IW:0];
    raddr_inc = org16 ? {1'b0, raddr[IW-1:0] + 1'b1} : raddr + 1'b1;
    ridx    = org16 ? raddr[IW-1:0] : raddr[IW:1];
    if (org16)         ld_word = rdata;
    else if (raddr[0]) ld_word = {rdata[7:0], 8'h00};
    else               ld_word = {rdata[15:8], 8'h00};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; bcnt <= '0; hdr_q <= '0; dat_q <= '0; sh_q <= '0;
      raddr <= '0; wcnt <= '0; arm_op <= P_WRITE; arm_addr <= '0;
      pgm_op <= P_WRITE; pgm_addr <= '0; pgm_data <= '0; pgm_org <= 1'b1;
      busy <= 1'b0; wen <= 1'b0; stat_pend <= 1'b0; stat_clr <= 1'b0;
      rd_oe <= 1'b0; rd_do <= 1'b0; pcnt <= '0;
    end else begin
      if (busy) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == PW'(PROG_T - 1)) busy <= 1'b0;
      end
      if (cs_fall) begin
        st       <= S_IDLE;
        rd_oe    <= 1'b0;
        stat_clr <= 1'b0;
        if (st == S_ARMED && wen && pe && !busy) begin
          busy      <= 1'b1;
          pcnt      <= '0;
          pgm_op    <= arm_op;
          pgm_addr  <= arm_addr;
          pgm_data  <= dat_q;
          pgm_org   <= org16;
          stat_pend <= 1'b1;
        end else if (!busy) begin
          stat_pend <= 1'b0;
        end
      end else if (cs_s && sk_rise) begin
        unique case (st)
          S_IDLE: if (di_s && !busy) begin
            st   <= S_HDR;
            bcnt <= '0;
            if (stat_pend) stat_clr <= 1'b1;
          end
          S_HDR: begin
            hdr_q <= hdr_n;
            bcnt  <= bcnt + 1'b1;
            if (bcnt == hlast) begin
              arm_addr <= a_dec;
              unique case (op_dec)
                OPC_READ: begin
                  st <= S_READ; raddr <= a_dec; rd_oe <= 1'b1;
                  rd_do <= 1'b0; wcnt <= '0;
                end
                OPC_WRITE: begin st <= S_DATA; bcnt <= '0; arm_op <= P_WRITE; end
                OPC_ERASE: begin st <= S_ARMED; arm_op <= P_ERASE; end
                default: unique case (sel_dec)
                  SEL_WEN:  begin wen <= 1'b1; st <= S_DONE; end
                  SEL_WDIS: begin wen <= 1'b0; st <= S_DONE; end
                  SEL_WIPE: begin st <= S_ARMED; arm_op <= P_WIPE; end
                  default:  begin st <= S_DATA; bcnt <= '0; arm_op <= P_FILL; end
                endcase
              endcase
            end
          end
          S_DATA: begin
            dat_q <= {dat_q[14:0], di_s};
            bcnt  <= bcnt + 1'b1;
            if (bcnt == dlast) st <= S_ARMED;
          end
          S_READ: begin
            if (wcnt == '0) begin
              rd_do <= ld_word[15];
              sh_q  <= {ld_word[14:0], 1'b0};
              wcnt  <= org16 ? 5'd15 : 5'd7;
              raddr <= raddr_inc;
            end else begin
              rd_do <= sh_q[15];
              sh_q  <= {sh_q[14:0], 1'b0};
              wcnt  <= wcnt - 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (cs_s && sk_fall && stat_clr) begin
        stat_pend <= 1'b0;
        stat_clr  <= 1'b0;
      end
    end
  end

  // program engine: one write for single ops, a sweep for array-wide ops
  always_comb begin
    all_op = (pgm_op == P_WIPE) || (pgm_op == P_FILL);
    if (all_op) begin
      we_hi = busy && (pcnt < PW'(MEM_WORDS));
      we_lo = we_hi;
      widx  = pcnt[IW-1:0];
    end else begin
      we_hi = busy && (pcnt == '0) && (pgm_org || !pgm_addr[0]);
      we_lo = busy && (pcnt == '0) && (pgm_org || pgm_addr[0]);
      widx  = pgm_org ? pgm_addr[IW-1:0] : pgm_addr[IW:1];
    end
    if (pgm_op == P_ERASE || pgm_op == P_WIPE) wdata = 16'hFFFF;
    else if (pgm_org)                           wdata = pgm_data;
    else                                        wdata = {pgm_data[7:0], pgm_data[7:0]};
  end

  assign busy_o  = busy;
  assign wen_o   = wen;
  assign stat_o  = stat_pend;
  assign rd_oe_o = rd_oe;
  assign rd_do_o = rd_do;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_BITS   = 10,
  parameter int MEM_WORDS   = 64,
  parameter int PROG_CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org16_i,
  input  logic pe_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int IW     = $clog2(MEM_WORDS);
  localparam int PROG_T = (PROG_CYCLES > MEM_WORDS) ? PROG_CYCLES : MEM_WORDS + 1;

  logic [4:0]    pin_s, pin_r, pin_f;
  logic          cs_s, busy, wen, stat, rd_oe, rd_do, we_hi, we_lo, mem_we_any;
  logic [IW-1:0] ridx, widx;
  logic [15:0]   rdata, wdata;

  mw_sync #(.W(5)) u_sync (
    .clk(clk), .rst(rst),
    .din({pe_i, org16_i, di_i, sk_i, cs_i}),
    .sync_o(pin_s), .rise_o(pin_r), .fall_o(pin_f)
  );

  assign cs_s = pin_s[0];

  mw_ctrl #(
    .ADDR_BITS(ADDR_BITS), .IW(IW), .MEM_WORDS(MEM_WORDS), .PROG_T(PROG_T)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cs_s(cs_s), .cs_fall(pin_f[0]),
    .sk_rise(pin_r[1]), .sk_fall(pin_f[1]), .di_s(pin_s[2]),
    .org16(pin_s[3]), .pe(pin_s[4]), .rdata(rdata), .ridx(ridx),
    .we_hi(we_hi), .we_lo(we_lo), .widx(widx), .wdata(wdata),
    .busy_o(busy), .wen_o(wen), .stat_o(stat), .rd_oe_o(rd_oe), .rd_do_o(rd_do)
  );

  mw_mem #(.IW(IW)) u_mem (
    .clk(clk), .we_hi(we_hi), .we_lo(we_lo), .widx(widx), .wdata(wdata),
    .ridx(ridx), .rdata(rdata)
  );

  assign mem_we_any = we_hi | we_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      do_oe_o <= 1'b0;
      do_o    <= 1'b0;
    end else begin
      do_oe_o <= cs_s & (stat | rd_oe);
      do_o    <= stat ? ~busy : rd_do;
    end
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic busy,
  input logic wen,
  input logic mem_we_any,
  input logic do_o,
  input logic do_oe_o
);
  // R14
  idle_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cs_s) |-> !do_oe_o);
  // R9
  busy_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(cs_s)) |-> (do_oe_o && !do_o));
  // R8
  reset_wdis_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wen);
  // R5
  store_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_any |-> busy);
  // R9
  busy_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .busy(busy), .wen(wen),
  .mem_we_any(mem_we_any), .do_o(do_o), .do_oe_o(do_oe_o)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int AW   = 10;
  localparam int MW   = 16;
  localparam int PC   = 400;
  localparam int PT   = 400;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
  logic do_o, do_oe_o;
  int total = 0, fails = 0;
  logic [7:0] m_hi [MW];
  logic [7:0] m_lo [MW];

  always #10 clk = ~clk;

  mw_eeprom #(.ADDR_BITS(AW), .MEM_WORDS(MW), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di),
    .org16_i(org), .pe_i(pe), .do_o(do_o), .do_oe_o(do_oe_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 0, 1);
    finish_run();
  end

  function automatic logic [15:0] exp_rd(int a, bit o16);
    int w;
    if (o16) begin
      w = a % MW;
      return {m_hi[w], m_lo[w]};
    end
    w = (a % (2 * MW)) / 2;
    return {8'h00, (a % 2) ? m_lo[w] : m_hi[w]};
  endfunction

  function automatic void mdl_store(int a, bit o16, logic [15:0] d);
    int w;
    if (o16) begin
      w = a % MW; m_hi[w] = d[15:8]; m_lo[w] = d[7:0];
    end else begin
      w = (a % (2 * MW)) / 2;
      if (a % 2) m_lo[w] = d[7:0]; else m_hi[w] = d[7:0];
    end
  endfunction

  function automatic void mdl_fill(logic [7:0] h, logic [7:0] l);
    for (int i = 0; i < MW; i++) begin m_hi[i] = h; m_lo[i] = l; end
  endfunction

  task automatic clk_n(int n); repeat (n) @(negedge clk); endtask

  task automatic pulse(bit b);
    di = b; clk_n(HALF); sk = 1'b1; clk_n(HALF); sk = 1'b0;
  endtask

  task automatic send(int unsigned v, int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic cs_on();  cs = 1'b1; clk_n(4); endtask
  task automatic cs_off(); cs = 1'b0; clk_n(8); endtask

  task automatic instr(int op, int a, bit o16, int lead = 0);
    cs_on();
    for (int i = 0; i < lead; i++) pulse(1'b0);
    pulse(1'b1);
    send(op, 2);
    send(a, o16 ? AW : AW + 1);
  endtask

  task automatic do_write(int a, int d, bit o16);
    instr(1, a, o16);
    send(d, o16 ? 16 : 8);
  endtask

  task automatic wait_ready(string tag);
    int cnt;
    cs_off(); cnt = 8;
    cs = 1'b1; clk_n(8); cnt += 8;
    check(do_oe_o && !do_o, {"R9 busy shown ", tag}, {do_oe_o, do_o}, 2'b10);
    while (!do_o && cnt < PT + 200) begin clk_n(1); cnt++; end
    check(do_o && do_oe_o && cnt >= PT && cnt <= PT + 20, {"R9 busy length ", tag}, cnt, PT);
    pulse(1'b1);
    clk_n(6);
    check(!do_oe_o, {"R10 release ", tag}, do_oe_o, 0);
    cs_off();
  endtask

  task automatic expect_quiet(string tag);
    cs_off();
    cs = 1'b1; clk_n(10);
    check(!do_oe_o, tag, do_oe_o, 0);
    cs_off();
  endtask

  task automatic read_chk(int a, int n, bit o16, string tag, int lead = 0);
    logic [15:0] v;
    int dw;
    dw = o16 ? 16 : 8;
    instr(2, a, o16, lead);
    check(do_oe_o && !do_o, {"R3 dummy zero ", tag}, {do_oe_o, do_o}, 2'b10);
    for (int w = 0; w < n; w++) begin
      v = '0;
      for (int b = 0; b < dw; b++) begin
        pulse(1'b0);
        v = {v[14:0], do_o};
      end
      check(v == exp_rd(a + w, o16), tag, v, exp_rd(a + w, o16));
    end
    cs_off();
  endtask

  initial begin
    logic [15:0] d1, d2;
    int a;
    void'($urandom(32'h1234));
    clk_n(5); rst = 1'b0; clk_n(3);
    check(!do_oe_o && !do_o, "R14 reset state", {do_oe_o, do_o}, 0);

    // enable, then erase-all (R2, R6)
    instr(0, 3 << (AW - 2), 1); cs_off();
    instr(0, 2 << (AW - 2), 1); wait_ready("wipe");
    mdl_fill(8'hFF, 8'hFF);
    read_chk(0, MW + 2, 1, "R6 wipe then R4 wrap");

    // random writes over erased data (R5)
    for (int i = 0; i < MW; i++) begin
      d1 = 16'($urandom);
      do_write(i, d1, 1); wait_ready("R5 fill loop");
      mdl_store(i, 1, d1);
    end
    d1 = 16'($urandom);
    do_write(4, d1, 1); wait_ready("R5 overwrite");
    mdl_store(4, 1, d1);
    read_chk(4, 1, 1, "R5 overwrite without erase");
    read_chk(MW - 2, 4, 1, "R4 sequential wrap x16");

    // single erase (R6)
    instr(3, 5, 1); wait_ready("erase");
    mdl_store(5, 1, 16'hFFFF);
    read_chk(5, 1, 1, "R6 single erase");

    // aliasing above depth (R13)
    d1 = 16'($urandom);
    do_write(MW + 9, d1, 1); wait_ready("alias");
    mdl_store(9, 1, d1);
    read_chk(9, 1, 1, "R13 high address bits ignored");

    // abort mid data (R12)
    instr(1, 2, 1); send(16'hBEEF >> 8, 8); cs_off();
    read_chk(2, 1, 1, "R12 aborted write");

    // leading zeros before start bit (R1)
    read_chk(7, 1, 1, "R1 leading zeros ignored", 3);

    // byte organization (R11)
    org = 1'b0;
    do_write(7, 8'h5A, 0); wait_ready("byte odd");  mdl_store(7, 0, 16'h005A);
    do_write(6, 8'hC3, 0); wait_ready("byte even"); mdl_store(6, 0, 16'h00C3);
    read_chk(6, 2, 0, "R11 byte read");
    for (int i = 0; i < 4; i++) begin
      a = int'($urandom % (2 * MW));
      d1 = 16'($urandom % 256);
      do_write(a, d1, 0); wait_ready("byte random");
      mdl_store(a, 0, d1);
      read_chk(a, 1, 0, "R11 byte random");
    end
    read_chk(2 * MW - 1, 3, 0, "R4 sequential wrap x8");
    org = 1'b1;
    read_chk(3, 1, 1, "R11 lane mapping in word view");

    // write protection (R8)
    instr(0, 0, 1); cs_off();
    do_write(1, 16'h1111, 1); expect_quiet("R8 disabled write no busy");
    read_chk(1, 1, 1, "R8 disabled write ignored");
    pe = 1'b0;
    instr(0, 3 << (AW - 2), 1); cs_off();
    do_write(1, 16'h2222, 1); expect_quiet("R8 pe low no busy");
    read_chk(1, 1, 1, "R8 pe low write ignored");
    pe = 1'b1;
    do_write(1, 16'h3333, 1); wait_ready("R8 enable with pe low");
    mdl_store(1, 1, 16'h3333);
    read_chk(1, 1, 1, "R8 enable accepted with pe low");
    rst = 1'b1; clk_n(3); rst = 1'b0; clk_n(3);
    do_write(0, 16'h4444, 1); expect_quiet("R8 reset disables writes");
    read_chk(0, 1, 1, "R8 after reset write ignored");
    instr(0, 3 << (AW - 2), 1); cs_off();

    // instruction while busy is ignored (R9)
    d1 = 16'($urandom);
    do_write(10, d1, 1); cs_off();
    mdl_store(10, 1, d1);
    cs = 1'b1; clk_n(4);
    pulse(1'b1); send(3, 2); send(11, AW);
    cs_off(); clk_n(PT);
    cs_on(); cs_off();
    read_chk(10, 2, 1, "R9 erase during busy ignored");

    // fill in both organizations (R7)
    instr(0, 1 << (AW - 2), 1); send(16'hA5C3, 16); wait_ready("fill16");
    mdl_fill(8'hA5, 8'hC3);
    read_chk(0, MW, 1, "R7 fill x16");
    org = 1'b0;
    instr(0, 1 << (AW - 1), 0); send(8'h3C, 8); wait_ready("fill8");
    mdl_fill(8'h3C, 8'h3C);
    read_chk(2 * MW - 3, 6, 0, "R7 fill x8");
    org = 1'b1;
    cs = 1'b0; clk_n(4);
    check(!do_oe_o, "R14 deselected output off", do_oe_o, 0);
    finish_run();
  end
endmodule